// File: doc/BRIEF.md
# Coprocessor Escape Snooper and Operand Mover

This block sits next to a host processor on a shared memory bus and never gets instructions handed to it. Instead it keeps a private copy of the host's instruction prefetch queue. It fills that copy from every byte the host fetches and drains it by following the host's queue-status code. When the host takes a first instruction byte whose top five bits are 11011, the block treats it as an escape. It combines that byte with the following addressing byte into a 6-bit coprocessor opcode plus mod and r/m fields, and presents the result to an execution unit.

A register-form escape (mod = 11) only produces the decoded opcode. A memory form makes the host run exactly one operand cycle. The block snoops that cycle for the effective address. On a load it also keeps the data word, then requests the bus and reads the rest of the operand. On a store it throws the snooped word away and writes the whole operand itself from the store-data input. Operand length comes from the escape byte. A busy flag stays high from decode until the execution unit reports completion, so a host wait instruction can hold off the next escape.

Top module: `esc_snoop`

## Requirements
- R1: Only a first-byte pop (`q_stat` = 01) whose byte has bits [7:3] = 11011 starts an escape; any other first byte leaves `dec_valid` low and the block idle.
- R2: A subsequent-byte pop (`q_stat` = 10) right after an escape pulses `dec_valid` for one cycle, with `dec_op` = {escape[2:0], modrm[5:3]}, `dec_mod` = modrm[7:6] and `dec_rm` = modrm[2:0].
- R3: The mirrored queue appends `fetch_byte` on each `fetch_valid`, and each pop removes the oldest byte. `q_stat` = 11 discards every stored byte.
- R4: A register-form escape (mod = 11) raises neither `bus_req` nor `cp_valid`.
- R5: Operand length in 16-bit words is selected by escape bits [2:1]: 00 gives 2, 01 gives 4, 10 gives 5 and 11 gives 8.
- R6: On a load, the host cycle after decode (`hbus_valid`) gives `cap_addr` and `opnd_buf` word 0. The block then reads words 1 to N-1 at `cap_addr`+2k into `opnd_buf` word k, and pulses `opnd_valid` after the last one.
- R7: Modrm bits [5:4] = 11 mark a store. The snooped host data is discarded, and the block writes N words, `st_data` word k to `cap_addr`+2k, then pulses `opnd_valid`.
- R8: `cp_valid` is asserted only while `bus_gnt` is high. `bus_req` stays high until the cycle of the last transfer, where it is already low, and no transfer follows.
- R9: `busy` rises the cycle after a decode and stays high until the cycle after `exec_done`.
- R10: After reset, `busy`, `bus_req`, `cp_valid`, `dec_valid` and `opnd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Host fetched an instruction byte |
| fetch_byte | input | 8 | Fetched byte |
| q_stat | input | 2 | Host queue action: 00 none, 01 first byte, 10 next byte, 11 flush |
| hbus_valid | input | 1 | Host data cycle completes |
| hbus_addr | input | AW | Address of host data cycle |
| hbus_rdata | input | 16 | Data word of host cycle |
| bus_gnt | input | 1 | Bus granted to this block |
| cp_rdata | input | 16 | Read data for own transfer |
| st_data | input | 128 | Store operand, word k at bits 16k+15:16k |
| exec_done | input | 1 | Execution unit finished the instruction |
| bus_req | output | 1 | Bus request |
| cp_valid | output | 1 | Own transfer this cycle |
| cp_we | output | 1 | Own transfer is a write |
| cp_addr | output | AW | Own transfer address |
| cp_wdata | output | 16 | Own write data |
| dec_valid | output | 1 | Decode pulse |
| dec_op | output | 6 | Coprocessor opcode |
| dec_mod | output | 2 | Addressing mod field |
| dec_rm | output | 3 | r/m field or register index |
| cap_addr | output | AW | Captured effective address |
| opnd_buf | output | 128 | Load operand buffer |
| opnd_valid | output | 1 | Operand transfer finished |
| busy | output | 1 | Instruction in progress |

## Verification
The assertions rely on several properties of the host. It never pops from an empty queue, and it issues no new escape while `busy` is high. It runs its operand cycle only after a memory-form decode, and it keeps `st_data` stable during a store. The bench keeps to these rules: it pops only bytes it has already pushed, and it waits for `opnd_valid` and pulses `exec_done` before the next escape. Its arbiter grants one cycle after a request and withdraws the grant one cycle after the request drops, so grants stay back-to-back within an operand.

// File: rtl/esc_snoop.sv
module esc_snoop #(
  parameter int AW     = 20,
  parameter int QDEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid,
  input  logic [7:0]    fetch_byte,
  input  logic [1:0]    q_stat,
  input  logic          hbus_valid,
  input  logic [AW-1:0] hbus_addr,
  input  logic [15:0]   hbus_rdata,
  input  logic          bus_gnt,
  input  logic [15:0]   cp_rdata,
  input  logic [127:0]  st_data,
  input  logic          exec_done,
  output logic          bus_req,
  output logic          cp_valid,
  output logic          cp_we,
  output logic [AW-1:0] cp_addr,
  output logic [15:0]   cp_wdata,
  output logic          dec_valid,
  output logic [5:0]    dec_op,
  output logic [1:0]    dec_mod,
  output logic [2:0]    dec_rm,
  output logic [AW-1:0] cap_addr,
  output logic [127:0]  opnd_buf,
  output logic          opnd_valid,
  output logic          busy
);
  localparam int QW = $clog2(QDEPTH);

  typedef enum logic [2:0] {S_IDLE, S_MODRM, S_HOST, S_MOVE, S_EXEC} state_t;

  state_t        state;
  logic [7:0]    q_mem [QDEPTH];
  logic [QW-1:0] q_rd, q_wr;
  logic [2:0]    esc_lo, len_m1, widx;
  logic          is_wr, reg_form;
  logic [AW-1:0] ptr;

  wire pop_first = (q_stat == 2'b01);
  wire pop_next  = (q_stat == 2'b10);
  wire flush     = (q_stat == 2'b11);
  wire [7:0] head = q_mem[q_rd];
  wire xfer = (state == S_MOVE) && bus_gnt;
  wire last = (widx == len_m1);

  assign cp_valid = xfer;
  assign cp_we    = xfer && is_wr;
  assign bus_req  = (state == S_MOVE) && !(xfer && last);
  assign cp_addr  = xfer ? ptr : '0;
  assign cp_wdata = (xfer && is_wr) ? st_data[{widx, 4'b0000} +: 16] : 16'h0000;
  assign busy     = (state == S_HOST) || (state == S_MOVE) || (state == S_EXEC);

  function automatic logic [2:0] words_m1(input logic [1:0] sel);
    case (sel)
      2'b00:   return 3'd1;
      2'b01:   return 3'd3;
      2'b10:   return 3'd4;
      default: return 3'd7;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (fetch_valid && !flush) q_mem[q_wr] <= fetch_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      q_rd <= '0;
      q_wr <= '0;
    end else begin
      if (fetch_valid)          q_wr <= q_wr + 1'b1;
      if (pop_first || pop_next) q_rd <= q_rd + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      dec_valid  <= 1'b0;
      opnd_valid <= 1'b0;
      dec_op     <= '0;
      dec_mod    <= '0;
      dec_rm     <= '0;
      esc_lo     <= '0;
      len_m1     <= '0;
      widx       <= '0;
      is_wr      <= 1'b0;
      reg_form   <= 1'b0;
      ptr        <= '0;
      cap_addr   <= '0;
      opnd_buf   <= '0;
    end else begin
      dec_valid  <= 1'b0;
      opnd_valid <= 1'b0;
      case (state)
        S_IDLE, S_MODRM: begin
          if (flush) begin
            state <= S_IDLE;
          end else if (pop_first) begin
            if (head[7:3] == 5'b11011) begin
              esc_lo <= head[2:0];
              state  <= S_MODRM;
            end else begin
              state <= S_IDLE;
            end
          end else if (pop_next && state == S_MODRM) begin
            dec_valid <= 1'b1;
            dec_op    <= {esc_lo, head[5:3]};
            dec_mod   <= head[7:6];
            dec_rm    <= head[2:0];
            len_m1    <= words_m1(esc_lo[2:1]);
            is_wr     <= (head[5:4] == 2'b11);
            reg_form  <= (head[7:6] == 2'b11);
            state     <= (head[7:6] == 2'b11) ? S_EXEC : S_HOST;
          end
        end
        S_HOST: begin
          if (hbus_valid) begin
            cap_addr <= hbus_addr;
            if (is_wr) begin
              ptr  <= hbus_addr;
              widx <= 3'd0;
            end else begin
              opnd_buf[15:0] <= hbus_rdata;
              ptr  <= hbus_addr + AW'(2);
              widx <= 3'd1;
            end
            state <= S_MOVE;
          end
        end
        S_MOVE: begin
          if (xfer) begin
            if (!is_wr) opnd_buf[{widx, 4'b0000} +: 16] <= cp_rdata;
            widx <= widx + 3'd1;
            ptr  <= ptr + AW'(2);
            if (last) begin
              opnd_valid <= 1'b1;
              state      <= S_EXEC;
            end
          end
        end
        default: begin
          if (exec_done) state <= S_IDLE;
        end
      endcase
    end
  end

  AST_DRIVE_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    cp_valid |-> bus_gnt); // R8
  AST_NO_XFER_AFTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_valid && !bus_req) |=> !cp_valid); // R8
  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> busy); // R8
  AST_REGFORM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_form) |-> (!bus_req && !cp_valid)); // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_valid && $past(cp_valid)) |-> (cp_addr == $past(cp_addr) + AW'(2))); // R6
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !exec_done) |=> busy); // R9
  AST_DEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid); // R2
endmodule

// File: tb/tb_esc_snoop.sv
module tb_esc_snoop;
  localparam int AW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_valid = 1'b0;
  logic [7:0] fetch_byte = '0;
  logic [1:0] q_stat = '0;
  logic hbus_valid = 1'b0;
  logic [AW-1:0] hbus_addr = '0;
  logic [15:0] hbus_rdata = '0;
  logic bus_gnt;
  logic [15:0] cp_rdata;
  logic [127:0] st_data = '0;
  logic exec_done = 1'b0;
  logic bus_req, cp_valid, cp_we, dec_valid, opnd_valid, busy;
  logic [AW-1:0] cp_addr, cap_addr;
  logic [15:0] cp_wdata;
  logic [5:0] dec_op;
  logic [1:0] dec_mod;
  logic [2:0] dec_rm;
  logic [127:0] opnd_buf;

  logic [15:0] mem [64];
  int n_chk = 0, n_err = 0;
  int n_xfer = 0, n_req = 0, n_dec = 0;

  always #5 clk = ~clk;

  esc_snoop #(.AW(AW), .QDEPTH(8)) dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_byte(fetch_byte),
    .q_stat(q_stat), .hbus_valid(hbus_valid), .hbus_addr(hbus_addr),
    .hbus_rdata(hbus_rdata), .bus_gnt(bus_gnt), .cp_rdata(cp_rdata),
    .st_data(st_data), .exec_done(exec_done), .bus_req(bus_req),
    .cp_valid(cp_valid), .cp_we(cp_we), .cp_addr(cp_addr), .cp_wdata(cp_wdata),
    .dec_valid(dec_valid), .dec_op(dec_op), .dec_mod(dec_mod), .dec_rm(dec_rm),
    .cap_addr(cap_addr), .opnd_buf(opnd_buf), .opnd_valid(opnd_valid), .busy(busy)
  );

  assign cp_rdata = mem[cp_addr[6:1]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_gnt <= 1'b0;
      for (int i = 0; i < 64; i++) mem[i] <= 16'hC000 + 16'(i * 3);
    end else begin
      bus_gnt <= bus_req;
      if (cp_valid && cp_we) mem[cp_addr[6:1]] <= cp_wdata;
    end
  end

  always @(posedge clk) begin
    if (cp_valid) n_xfer++;
    if (bus_req) n_req++;
    if (dec_valid) n_dec++;
  end

  function automatic logic [15:0] init_word(input int idx);
    return 16'hC000 + 16'(idx * 3);
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic feed(input logic [7:0] b);
    fetch_valid = 1'b1; fetch_byte = b;
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  task automatic pop(input logic [1:0] k);
    q_stat = k;
    @(negedge clk);
    q_stat = 2'b00;
  endtask

  task automatic issue(input logic [7:0] esc, input logic [7:0] modrm);
    feed(esc); feed(modrm);
    pop(2'b01); pop(2'b10);
  endtask

  task automatic host_cycle(input logic [AW-1:0] a, input logic [15:0] d);
    hbus_valid = 1'b1; hbus_addr = a; hbus_rdata = d;
    @(negedge clk);
    hbus_valid = 1'b0;
  endtask

  task automatic wait_opnd(input string tag);
    for (int i = 0; i < 40; i++) begin
      if (opnd_valid) break;
      @(negedge clk);
    end
    chk({tag, " opnd_valid"}, opnd_valid, 1'b1);
  endtask

  task automatic finish_exec(input string tag);
    chk({tag, " busy held"}, busy, 1'b1);
    exec_done = 1'b1;
    @(negedge clk);
    exec_done = 1'b0;
    chk({tag, " busy cleared"}, busy, 1'b0);
  endtask

  task automatic t_reset;
    chk("R10 busy", busy, 1'b0);
    chk("R10 bus_req", bus_req, 1'b0);
    chk("R10 cp_valid", cp_valid, 1'b0);
    chk("R10 dec_valid", dec_valid, 1'b0);
    chk("R10 opnd_valid", opnd_valid, 1'b0);
  endtask

  task automatic t_load(input logic [7:0] esc, input logic [7:0] modrm, input logic [AW-1:0] a,
                        input logic [15:0] hd, input int nw, input logic [5:0] op, input string tag);
    int x0, d0;
    logic [127:0] exp;
    x0 = n_xfer; d0 = n_dec;
    issue(esc, modrm);
    chk({tag, " R2 dec_valid"}, dec_valid, 1'b1);
    chk({tag, " R2 dec_op"}, dec_op, op);
    chk({tag, " R2 dec_rm"}, dec_rm, modrm[2:0]);
    chk({tag, " R9 busy after decode"}, busy, 1'b1);
    feed(8'h12); pop(2'b10);
    host_cycle(a, hd);
    wait_opnd(tag);
    exp = '0;
    exp[15:0] = hd;
    for (int k = 1; k < nw; k++) exp[16*k +: 16] = init_word(int'(a >> 1) + k);
    chk({tag, " R6 cap_addr"}, cap_addr, a);
    chk({tag, " R6 operand"}, opnd_buf & ((128'd1 << (16*nw)) - 1), exp);
    chk({tag, " R5 transfer count"}, n_xfer - x0, nw - 1);
    chk({tag, " R8 req dropped"}, bus_req, 1'b0);
    chk({tag, " R2 one decode"}, n_dec - d0, 1);
    finish_exec(tag);
  endtask

  task automatic t_store;
    int x0;
    st_data = {64'h0, 16'h4444, 16'h3333, 16'h2222, 16'h1111};
    x0 = n_xfer;
    issue(8'hDA, 8'h36);
    chk("R2 store dec_op", dec_op, 6'b010110);
    host_cycle(20'h00050, 16'hDEAD);
    wait_opnd("R7 store");
    chk("R7 transfer count", n_xfer - x0, 4);
    for (int k = 0; k < 4; k++)
      chk("R7 written word", mem[40 + k], 16'h1111 * 16'(k + 1));
    chk("R7 neighbour untouched", mem[44], init_word(44));
    chk("R7 cap_addr", cap_addr, 20'h00050);
    finish_exec("R7 store");
  endtask

  task automatic t_regform;
    int r0;
    r0 = n_req;
    issue(8'hD9, 8'hE9);
    chk("R2 reg dec_op", dec_op, 6'h0D);
    chk("R2 reg dec_mod", dec_mod, 2'b11);
    chk("R2 reg dec_rm", dec_rm, 3'd1);
    repeat (6) @(negedge clk);
    chk("R4 no bus request", n_req - r0, 0);
    finish_exec("R9 reg");
  endtask

  task automatic t_nonesc;
    int d0;
    d0 = n_dec;
    feed(8'h90); feed(8'hC8); feed(8'h06);
    pop(2'b01); pop(2'b01); pop(2'b10);
    repeat (2) @(negedge clk);
    chk("R1 no decode for non-escape", n_dec - d0, 0);
    chk("R1 idle", busy, 1'b0);
  endtask

  task automatic t_flush;
    int d0;
    d0 = n_dec;
    feed(8'hD8); feed(8'h06);
    pop(2'b11);
    feed(8'h90); feed(8'h06);
    pop(2'b01); pop(2'b10);
    repeat (2) @(negedge clk);
    chk("R3 flushed bytes not decoded", n_dec - d0, 0);
    issue(8'hDB, 8'hC2);
    chk("R3 aligned after flush", dec_op, 6'b011000);
    finish_exec("R3 flush");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nonesc();
    t_regform();
    t_load(8'hD8, 8'h06, 20'h00010, 16'h1357, 2, 6'h00, "R5 len2");
    t_load(8'hDA, 8'h05, 20'h00070, 16'h2468, 4, 6'h10, "R5 len4");
    t_load(8'hDC, 8'h8C, 20'h00060, 16'hBEEF, 5, 6'h21, "R5 len5");
    t_load(8'hDE, 8'h45, 20'h00030, 16'hCAFE, 8, 6'h30, "R5 len8");
    t_store();
    t_flush();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule